// File: doc/BRIEF.md
# Transport-Stream Ping-Pong Capture Engine

This block takes an MPEG transport stream delivered one byte per cycle with a valid strobe and a start-of-packet flag. It locks onto packet boundaries using the 0x47 sync byte and writes whole 188-byte packets into a ring buffer made of two equal halves. Each half holds eight packets (1504 bytes), so the ring spans 3008 byte addresses. When the last byte of a half reaches memory, a status bit for that half is set. After the end of the second half, writing continues at address 0 without any software action.

Accepted bytes go through a small FIFO to a byte-wide memory write port that can be stalled. Software controls the block through four 32-bit registers: a capture-enable register, a write-one-to-clear interrupt status register, an interrupt mask and a general control register that carries a soft-reset command. Framing faults and FIFO overflow are reported as status bits. When such a fault occurs, the block drops the packet it was building and locks onto the stream again.

Register map (reg_addr): 0 = capture enable, 1 = interrupt status, 2 = interrupt mask, 3 = general control. Status bits: 0 = first half done, 4 = second half done, 8 = framing error, 9 = overflow.

Top module: `ts_pingpong_cap`

## Requirements
- R1: After reset, all registers read 0, irq is low and mem_we is low.
- R2: Bytes are captured only while capture-enable bits 0 and 4 are both 1. Writing 0 stops capture. While stopped, input is dropped and any partial packet is abandoned, so the next packet is written from that packet's start address.
- R3: While hunting for a packet boundary (after reset, after a stop, or after a fault), every byte is discarded until one arrives that equals 0x47 with in_sop high.
- R4: Captured bytes go to consecutive addresses starting at 0. After address 3007 (2 x 8 x 188 - 1) the next address is 0.
- R5: Status bit 0 is set when the byte at address 1503 is written to memory. Status bit 4 is set when the byte at address 3007 is written.
- R6: irq is high exactly when some status bit is 1 and the same bit of the mask register (address 2) is 1.
- R7: Writing a 1 to a status bit at address 1 clears that bit. Writing a 0 leaves the bit unchanged.
- R8: Status bit 8 is set in two cases, and the partial packet is dropped. First, when the byte at a packet boundary is not 0x47 with in_sop; the block then returns to hunting. Second, when in_sop rises inside a packet; writing then resumes at that packet's start, and a 0x47 byte arriving with that in_sop begins a new packet there.
- R9: A byte that would be accepted while the FIFO is full sets sticky status bit 8+1 (bit 9). That byte is dropped and the packet is abandoned.
- R10: Writing a value with bit 6 set to address 3 resets the capture path. The next packet is written at address 0, and the other registers keep their values.
- R11: While mem_ready is low, the pending write (mem_we, mem_addr, mem_wdata) is held unchanged, and no data is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte valid |
| in_sop | input | 1 | Start-of-packet flag |
| in_data | input | 8 | Stream byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_we | output | 1 | Buffer write request |
| mem_addr | output | 12 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| irq | output | 1 | Masked interrupt |

## Verification
The overflow path is the hardest to reach from the ports. The FIFO drains one byte every cycle, so it fills only when memory stalls. The bench therefore holds mem_ready low while a packet arrives, checks that the pending write stays frozen, then releases memory and confirms that the abandoned packet's start address is reused. Mid-packet realignment is reached by cutting a packet short with a fresh in_sop. Reaching both halves and the ring wrap needs more than a full ring of packets with random gaps, and the final buffer image is compared against a model kept in the bench.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
    localparam logic [1:0] A_CTL  = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_MASK = 2'd2;
    localparam logic [1:0] A_GEN  = 2'd3;

    localparam int B_LO   = 0;
    localparam int B_HI   = 4;
    localparam int B_ERR  = 8;
    localparam int B_OVF  = 9;
    localparam int B_FIFO = 0;
    localparam int B_ENG  = 4;
    localparam int B_SRST = 6;

    localparam logic [31:0] STAT_BITS = 32'h0000_0311;
    localparam logic [31:0] CTL_BITS  = 32'h0000_0011;

    typedef enum logic [1:0] {ST_HUNT, ST_PKT, ST_NEXT} align_st_t;

    typedef struct packed {
        logic       last_lo;
        logic       last_hi;
        logic [7:0] data;
    } beat_t;

    function automatic logic is_sync(input logic sop, input logic [7:0] d, input logic [7:0] sync);
        return sop && (d == sync);
    endfunction
endpackage

// File: rtl/ts_align.sv
module ts_align
    import ts_cap_pkg::*;
#(
    parameter int PKT_BYTES = 188,
    parameter int PKTS_HALF = 8,
    parameter logic [7:0] SYNC = 8'h47,
    localparam int HALF  = PKT_BYTES * PKTS_HALF,
    localparam int TOTAL = 2 * HALF,
    localparam int AW    = $clog2(TOTAL),
    localparam int CW    = $clog2(PKT_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          run,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic [7:0]    in_data,
    input  logic          fifo_full,
    output logic          push,
    output logic [AW-1:0] push_addr,
    output beat_t         push_beat,
    output logic          err_pulse,
    output logic          ovf_pulse
);
    align_st_t     state;
    logic [CW-1:0] cnt;
    logic [AW-1:0] wptr, base, nxt;
    logic          want, begin_pkt, abandon, pkt_last, start;

    assign start = is_sync(in_sop, in_data, SYNC);

    always_comb begin
        want = 1'b0; begin_pkt = 1'b0; abandon = 1'b0; err_pulse = 1'b0; ovf_pulse = 1'b0;
        if (run && in_valid) begin
            unique case (state)
                ST_HUNT: if (start) begin want = 1'b1; begin_pkt = 1'b1; end
                ST_PKT: begin
                    if (in_sop) begin
                        err_pulse = 1'b1; abandon = 1'b1;
                        if (start) begin want = 1'b1; begin_pkt = 1'b1; end
                    end else want = 1'b1;
                end
                default: begin
                    if (start) begin want = 1'b1; begin_pkt = 1'b1; end
                    else err_pulse = 1'b1;
                end
            endcase
        end
        push = want && !fifo_full;
        if (want && fifo_full) begin
            ovf_pulse = 1'b1; abandon = 1'b1; begin_pkt = 1'b0;
        end
    end

    assign push_addr = begin_pkt ? base : wptr;
    assign nxt       = (push_addr == AW'(TOTAL - 1)) ? '0 : push_addr + 1'b1;
    assign pkt_last  = push && !begin_pkt && (cnt == CW'(PKT_BYTES - 1));
    assign push_beat = '{last_lo: (push_addr == AW'(HALF - 1)),
                         last_hi: (push_addr == AW'(TOTAL - 1)),
                         data: in_data};

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state <= ST_HUNT; cnt <= '0; wptr <= '0; base <= '0;
        end else if (!run) begin
            state <= ST_HUNT; cnt <= '0; wptr <= base;
        end else if (push) begin
            wptr <= nxt;
            if (pkt_last) begin
                base <= nxt; state <= ST_NEXT; cnt <= '0;
            end else begin
                state <= ST_PKT; cnt <= begin_pkt ? CW'(1) : cnt + 1'b1;
            end
        end else if (abandon || err_pulse) begin
            wptr <= base; state <= ST_HUNT; cnt <= '0;
        end
    end

    a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (rst) push |-> !fifo_full);
    a_r2_push_needs_run:    assert property (@(posedge clk) disable iff (rst) push |-> run);
    a_r4_addr_in_ring:      assert property (@(posedge clk) disable iff (rst) push |-> (push_addr < AW'(TOTAL)));
endmodule

// File: rtl/ts_fifo.sv
module ts_fifo #(
    parameter int W     = 22,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd, wr;
    logic [NW-1:0] n;

    assign full  = (n == NW'(DEPTH));
    assign empty = (n == '0);
    assign dout  = mem[rd];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd <= '0; wr <= '0; n <= '0;
        end else begin
            if (push && !full) begin mem[wr] <= din; wr <= step(wr); end
            if (pop && !empty) rd <= step(rd);
            n <= n + NW'(push && !full) - NW'(pop && !empty);
        end
    end

    a_r11_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
        (!empty && !pop && !flush) |=> $stable(dout));
endmodule

// File: rtl/ts_regs.sv
module ts_regs
    import ts_cap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        set_lo,
    input  logic        set_hi,
    input  logic        set_err,
    input  logic        set_ovf,
    output logic        run,
    output logic        soft_rst,
    output logic        irq
);
    logic [31:0] ctl, status, mask, clr, set;

    assign clr      = (reg_we && reg_addr == A_STAT) ? (reg_wdata & STAT_BITS) : '0;
    assign set      = (32'(set_lo) << B_LO) | (32'(set_hi) << B_HI) |
                      (32'(set_err) << B_ERR) | (32'(set_ovf) << B_OVF);
    assign run      = ctl[B_FIFO] && ctl[B_ENG];
    assign soft_rst = reg_we && (reg_addr == A_GEN) && reg_wdata[B_SRST];
    assign irq      = |(status & mask);

    always_comb begin
        unique case (reg_addr)
            A_CTL:   reg_rdata = ctl;
            A_STAT:  reg_rdata = status;
            A_MASK:  reg_rdata = mask;
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0; status <= '0; mask <= '0;
        end else begin
            if (reg_we && reg_addr == A_CTL)  ctl  <= reg_wdata & CTL_BITS;
            if (reg_we && reg_addr == A_MASK) mask <= reg_wdata & STAT_BITS;
            status <= (status & ~clr) | set;
        end
    end

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_STAT && reg_wdata[B_LO] && !set_lo) |=> !status[B_LO]);
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (status[B_OVF] && !(reg_we && reg_addr == A_STAT && reg_wdata[B_OVF])) |=> status[B_OVF]);
    a_r5_half_sets: assert property (@(posedge clk) disable iff (rst)
        (set_lo || set_hi) |=> (status[B_LO] || status[B_HI]));
endmodule

// File: rtl/ts_pingpong_cap.sv
module ts_pingpong_cap
    import ts_cap_pkg::*;
#(
    parameter int PKT_BYTES  = 188,
    parameter int PKTS_HALF  = 8,
    parameter int FIFO_DEPTH = 4,
    parameter logic [7:0] SYNC = 8'h47,
    localparam int AW = $clog2(2 * PKT_BYTES * PKTS_HALF),
    localparam int EW = AW + $bits(beat_t)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic [7:0]    in_data,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ready,
    output logic          irq
);
    logic          run, soft_rst, push, err_p, ovf_p, full, empty, pop;
    logic [AW-1:0] push_addr;
    beat_t         push_beat, out_beat;
    logic [EW-1:0] f_out;

    ts_regs u_regs (
        .clk, .rst, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .set_lo(pop && out_beat.last_lo), .set_hi(pop && out_beat.last_hi),
        .set_err(err_p), .set_ovf(ovf_p),
        .run, .soft_rst, .irq
    );

    ts_align #(.PKT_BYTES(PKT_BYTES), .PKTS_HALF(PKTS_HALF), .SYNC(SYNC)) u_align (
        .clk, .rst, .flush(soft_rst), .run, .in_valid, .in_sop, .in_data,
        .fifo_full(full), .push, .push_addr, .push_beat,
        .err_pulse(err_p), .ovf_pulse(ovf_p)
    );

    ts_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk, .rst, .flush(soft_rst), .push, .din({push_addr, push_beat}),
        .pop, .dout(f_out), .full, .empty
    );

    assign out_beat  = f_out[$bits(beat_t)-1:0];
    assign mem_addr  = f_out[EW-1 -: AW];
    assign mem_wdata = out_beat.data;
    assign mem_we    = !empty;
    assign pop       = mem_we && mem_ready;

    a_r11_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_ready && !soft_rst) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: tb/ts_pingpong_cap_tb.sv
module ts_pingpong_cap_tb;
    localparam int PB = 188, HALF = PB * 8, TOT = 2 * HALF, FD = 4;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_sop = 0, reg_we = 0, mem_ready = 1;
    logic [7:0] in_data = 0;
    logic [1:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic mem_we, irq;
    logic [11:0] mem_addr;
    logic [7:0] mem_wdata;

    ts_pingpong_cap u_dut (.*);

    always #5 clk = ~clk;

    int errors = 0, checks = 0, nwr = 0, exp_ptr = 0;
    logic [7:0] ram [TOT];
    logic [7:0] expm [TOT];
    logic [7:0] pkt [PB];

    always begin
        @(negedge clk); #2;
        if (mem_we && mem_ready) begin ram[mem_addr] = mem_wdata; nwr++; end
    end

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, expv); end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic put(input logic sop, input logic [7:0] d);
        if ($urandom_range(3) == 0) begin @(negedge clk); in_valid = 0; end
        @(negedge clk); in_valid = 1; in_sop = sop; in_data = d;
    endtask

    task automatic idle(input int n);
        @(negedge clk); in_valid = 0; in_sop = 0;
        repeat (n) @(negedge clk);
    endtask

    // send the first n bytes of a fresh packet; record full packets in the model
    task automatic send(input int n, input bit rec);
        pkt[0] = 8'h47;
        for (int i = 1; i < PB; i++) pkt[i] = 8'($urandom);
        for (int i = 0; i < n; i++) put(i == 0, pkt[i]);
        idle(8);
        if (rec) begin
            for (int i = 0; i < PB; i++) expm[(exp_ptr + i) % TOT] = pkt[i];
            exp_ptr = (exp_ptr + PB) % TOT;
        end
    endtask

    function automatic int diff(input int lo, input int n);
        int m = 0;
        for (int i = 0; i < n; i++) if (ram[(lo + i) % TOT] !== expm[(lo + i) % TOT]) m++;
        return m;
    endfunction

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int w0, m;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk); rst = 0;
        // R1
        rd(2'd0, v); chk(v == 0, "R1 ctl", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 status", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 mask", v, 0);
        chk(!irq && !mem_we, "R1 irq/mem_we", {irq, mem_we}, 0);

        wr(2'd0, 32'h11);
        // R3: garbage, sync without sop, sop without sync
        for (int i = 0; i < 20; i++) put(0, 8'($urandom));
        put(0, 8'h47); put(1, 8'h12);
        idle(6);
        chk(nwr == 0, "R3 hunt discards", nwr, 0);
        rd(2'd1, v); chk(v == 0, "R3 no status", v, 0);

        // first half
        for (int p = 0; p < 8; p++) send(PB, 1);
        chk(nwr == HALF, "R4 write count half", nwr, HALF);
        m = diff(0, HALF); chk(m == 0, "R4 first half data", m, 0);
        rd(2'd1, v); chk(v == 32'h1, "R5 lo bit", v, 1);
        chk(!irq, "R6 masked off", irq, 0);
        wr(2'd2, 32'h11); #1;
        chk(irq, "R6 unmasked", irq, 1);
        wr(2'd1, 32'h0); rd(2'd1, v); chk(v == 32'h1, "R7 zero write keeps", v, 1);
        wr(2'd1, 32'h1); rd(2'd1, v); chk(v == 0, "R7 w1c", v, 0);
        chk(!irq, "R6 after clear", irq, 0);

        // second half
        for (int p = 0; p < 8; p++) send(PB, 1);
        m = diff(HALF, HALF); chk(m == 0, "R4 second half data", m, 0);
        rd(2'd1, v); chk(v == 32'h10, "R5 hi bit", v, 16);
        chk(irq, "R6 hi irq", irq, 1);
        wr(2'd1, 32'h10);

        // R4 wrap
        send(PB, 1);
        m = diff(0, PB); chk(m == 0 && exp_ptr == PB, "R4 wrap to 0", m, 0);

        // R8 missing sync at boundary
        put(1, 8'h55); idle(4);
        rd(2'd1, v); chk(v == 32'h100, "R8 boundary error", v, 256);
        send(PB, 1);
        m = diff(PB, PB); chk(m == 0, "R8 realign after boundary error", m, 0);
        wr(2'd1, 32'h100);

        // R8 sop inside packet
        send(100, 0);
        send(PB, 1);
        rd(2'd1, v); chk(v == 32'h100, "R8 mid-packet error", v, 256);
        m = diff(2 * PB, PB); chk(m == 0, "R8 restart at packet base", m, 0);
        wr(2'd1, 32'h100);

        // R9 / R11 overflow with stalled memory
        @(negedge clk); mem_ready = 0;
        w0 = nwr;
        send(PB, 0);
        chk(mem_we && nwr == w0, "R11 stalled hold", nwr, w0);
        chk(mem_addr == 12'(3 * PB) && mem_wdata == 8'h47, "R11 pending write", mem_addr, 3 * PB);
        @(negedge clk); mem_ready = 1;
        idle(8);
        chk(nwr == w0 + FD, "R11 no loss of queued bytes", nwr - w0, FD);
        rd(2'd1, v); chk(v == 32'h200, "R9 overflow bit", v, 512);
        send(PB, 1);
        rd(2'd1, v); chk(v[9], "R9 sticky", v, 512);
        m = diff(3 * PB, PB); chk(m == 0, "R9 packet base reused", m, 0);
        wr(2'd1, 32'h200);

        // R2 halt and single enable
        wr(2'd0, 32'h0); w0 = nwr;
        send(PB, 0);
        chk(nwr == w0, "R2 halted drops", nwr, w0);
        wr(2'd0, 32'h1);
        send(PB, 0);
        chk(nwr == w0, "R2 one enable bit", nwr, w0);
        wr(2'd0, 32'h11);
        send(50, 0);
        wr(2'd0, 32'h0); wr(2'd0, 32'h11);
        send(PB, 1);
        m = diff(4 * PB, PB); chk(m == 0, "R2 partial abandoned on stop", m, 0);

        // R10 soft reset
        wr(2'd3, 32'h40);
        exp_ptr = 0;
        send(PB, 1);
        m = diff(0, PB); chk(m == 0, "R10 restart at 0", m, 0);
        rd(2'd0, v); chk(v == 32'h11, "R10 ctl kept", v, 17);
        rd(2'd2, v); chk(v == 32'h11, "R10 mask kept", v, 17);

        // random run over a full ring
        wr(2'd1, 32'h311);
        for (int p = 0; p < 16; p++) send(PB, 1);
        rd(2'd1, v); chk(v == 32'h11, "R5 both halves", v, 17);
        m = diff(0, TOT); chk(m == 0, "R4 full ring image", m, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule